// File: doc/BRIEF.md
# Glitch-Free Selectable Clock-Out Divider

This block drives a square-wave clock output whose rate is taken from a free-running binary prescaler. The prescaler runs on a clock ticking at twice the fastest output rate, so each prescaler bit toggles at one of the available output rates. A 3-bit frequency field in an 8-bit control register selects the output. Six codes pick the fastest rates, halving each time from full rate down to 1/32 of it. One code picks the slow 1 Hz tap, which is the top bit of the prescaler chain that also feeds seconds counting. The last code turns the output off and holds it low.

The upper register bits are plain storage and have no effect on the output. A per-bit write mask lets a host rewrite the frequency field while leaving those bits as they were, which is what a read-modify-write sequence needs.

A change of code never produces a short pulse. The new code is adopted only when the current output goes low, or at once if the output is off. After a switch, the output stays low until the newly selected tap has been seen low and then rises. This guarantees that every high pulse lasts a full half period of the tap that produced it.

Top module: `clkout_divider`

## Requirements
- R1: After reset the register reads 0x00, the output is low during reset, and once running the output toggles every cycle (code 0, half period 1 cycle).
- R2: The register reads back what was written, merged through the mask: bits with a 0 in `regWmask` keep their old value, bits with a 1 take `regWdata`. With `regWe` low the register does not change.
- R3: Field bits [2:0] with codes 0 to 5 give a 50 % square wave whose high and low phases each last 2^code cycles.
- R4: Code 6 selects prescaler bit PRESC_W-1, giving high and low phases of 2^(PRESC_W-1) cycles each (32768 with the default width, i.e. 1 Hz at a 65536 Hz tick).
- R5: Code 7 holds the output low for as long as it stays selected.
- R6: While the output is running, a newly written code takes effect only at the next falling edge of the output. A high pulse in progress completes at its old full length.
- R7: After a switch, no high pulse is shorter than a half period of the tap that produces it.
- R8: A code written while the output is off is adopted at once. The first high pulse after that is a full half period of the new tap.
- R9: Register bits [7:3] are storage only. Writing them leaves the output rate unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Prescaler tick clock, twice the fastest output rate |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regWdata | input | 8 | Write data |
| regWmask | input | 8 | Per-bit write enable; 1 means the bit is written |
| regRdata | output | 8 | Current register contents |
| clkOut | output | 1 | Divided clock output, low when off |

## Verification
A register write is visible on `regRdata` straight after the clock edge that takes it. The frequency code reaches the output one edge after the next falling edge of `clkOut`, or one edge after the write when the output is off. The first pulse of the new rate then waits for the new tap's next natural rising edge.

Because that delay depends on the prescaler phase, the checks do not fix an absolute cycle for a switch. Instead they sample `clkOut` on the falling clock edge and measure whole high and low runs. They discard the first measurement after a rate change, except where the transition pulse itself is the subject (R6, R7, R8).

// File: rtl/clkout_pkg.sv
package clkout_pkg;
  localparam int CODE_W = 3;
  localparam int NUM_CODES = 2 ** CODE_W;
  localparam int FAST_CODES = 6;

  typedef enum logic [CODE_W-1:0] {
    F_FULL = 3'd0,
    F_HALF = 3'd1,
    F_QUART = 3'd2,
    F_DIV8 = 3'd3,
    F_DIV16 = 3'd4,
    F_DIV32 = 3'd5,
    F_SLOW = 3'd6,
    F_OFF = 3'd7
  } freqCode_e;

  typedef struct packed {
    logic apply;
    freqCode_e code;
  } ctrlStrobe_t;

  typedef struct packed {
    logic safe;
    freqCode_e active;
  } dpStatus_t;
endpackage

// File: rtl/clkout_ctrl.sv
module clkout_ctrl
  import clkout_pkg::*;
#(
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWe,
  input  logic [REG_W-1:0] regWdata,
  input  logic [REG_W-1:0] regWmask,
  output logic [REG_W-1:0] regRdata,
  input  dpStatus_t        dpStat,
  output ctrlStrobe_t      strobe
);
  logic [REG_W-1:0] ctrlReg;
  freqCode_e reqCode;

  always_ff @(posedge clk) begin
    if (!rstN) ctrlReg <= '0;
    else if (regWe) ctrlReg <= (ctrlReg & ~regWmask) | (regWdata & regWmask);
  end

  assign reqCode = freqCode_e'(ctrlReg[CODE_W-1:0]);
  assign regRdata = ctrlReg;

  // a pending code is handed over only when the datapath reports a safe edge
  assign strobe.apply = (reqCode != dpStat.active) && dpStat.safe;
  assign strobe.code = reqCode;

  // R2
  masked_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    regWe |=> (((ctrlReg ^ $past(ctrlReg)) & ~$past(regWmask)) == '0));

  // R2
  reg_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !regWe |=> $stable(ctrlReg));
endmodule

// File: rtl/clkout_datapath.sv
module clkout_datapath
  import clkout_pkg::*;
#(
  parameter int PRESC_W = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctrlStrobe_t strobe,
  output dpStatus_t   dpStat,
  output logic        clkOut
);
  localparam int SLOW_TAP = PRESC_W - 1;

  logic [PRESC_W-1:0] cnt, cntNext;
  logic [NUM_CODES-1:0] tapVec;
  freqCode_e activeCode;
  logic armed, clkOutQ, tapNext, outNext, unusedPresc;

  assign cntNext = cnt + {{(PRESC_W-1){1'b0}}, 1'b1};
  assign unusedPresc = ^cntNext;

  for (genvar i = 0; i < NUM_CODES; i++) begin : g_tap
    if (i < FAST_CODES) begin : g_fast
      assign tapVec[i] = cntNext[i];
    end else if (i == FAST_CODES) begin : g_slow
      assign tapVec[i] = cntNext[SLOW_TAP];
    end else begin : g_off
      assign tapVec[i] = 1'b0;
    end
  end

  assign tapNext = tapVec[activeCode];
  // a rise is allowed only once the tap has been seen low under this code
  assign outNext = (activeCode != F_OFF) && armed && tapNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= '0;
      activeCode <= F_FULL;
      armed <= 1'b0;
      clkOutQ <= 1'b0;
    end else begin
      cnt <= cntNext;
      if (strobe.apply) begin
        activeCode <= strobe.code;
        armed <= 1'b0;
        clkOutQ <= 1'b0;
      end else begin
        armed <= armed | ~tapNext;
        clkOutQ <= outNext;
      end
    end
  end

  assign dpStat.safe = (activeCode == F_OFF) || (clkOutQ && !outNext);
  assign dpStat.active = activeCode;
  assign clkOut = clkOutQ;

  // R6
  switch_at_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    (activeCode != $past(activeCode)) |->
      (($past(activeCode) == F_OFF) || ($past(clkOutQ) && !clkOutQ)));

  // R5
  off_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (activeCode == F_OFF) |-> !clkOutQ);

  // R7
  rise_steady_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(clkOutQ) |-> ((activeCode == $past(activeCode)) && (activeCode != F_OFF)));
endmodule

// File: rtl/clkout_divider.sv
module clkout_divider
  import clkout_pkg::*;
#(
  parameter int REG_W = 8,
  parameter int PRESC_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWe,
  input  logic [REG_W-1:0] regWdata,
  input  logic [REG_W-1:0] regWmask,
  output logic [REG_W-1:0] regRdata,
  output logic             clkOut
);
  ctrlStrobe_t strobe;
  dpStatus_t dpStat;

  clkout_ctrl #(.REG_W(REG_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regWdata(regWdata),
    .regWmask(regWmask), .regRdata(regRdata), .dpStat(dpStat), .strobe(strobe)
  );

  clkout_datapath #(.PRESC_W(PRESC_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .dpStat(dpStat), .clkOut(clkOut)
  );
endmodule

// File: tb/clkout_divider_tb.sv
module clkout_divider_tb;
  timeunit 1ns;
  timeprecision 1ps;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWe = 1'b0;
  logic [7:0] regWdata = '0;
  logic [7:0] regWmask = '0;
  wire [7:0] regRdata;
  wire clkOut;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  localparam int VCODE[6] = '{0, 1, 2, 3, 4, 5};
  localparam int VHALF[6] = '{1, 2, 4, 8, 16, 32};

  always #2 clk = ~clk;

  clkout_divider u_dut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regWdata(regWdata),
    .regWmask(regWmask), .regRdata(regRdata), .clkOut(clkOut)
  );

  task automatic check(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic writeReg(input logic [7:0] d, input logic [7:0] m);
    @(negedge clk);
    regWe = 1'b1; regWdata = d; regWmask = m;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic measure(output int hi, output int lo, input int limit);
    int n = 0;
    hi = 0; lo = 0;
    while (clkOut !== 1'b0 && n < limit) begin @(negedge clk); n++; end
    while (clkOut !== 1'b1 && n < limit) begin @(negedge clk); n++; end
    while (clkOut === 1'b1 && n < limit) begin hi++; @(negedge clk); n++; end
    while (clkOut === 1'b0 && n < limit) begin lo++; @(negedge clk); n++; end
  endtask

  initial begin
    #(190000 * 4);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int h, l, run, bad, seen16, highs;
    // R1 reset state
    repeat (4) @(negedge clk);
    check("R1", regRdata, 0, "register during reset");
    check("R1", clkOut, 0, "output during reset");
    rstN = 1'b1;
    measure(h, l, 100);
    check("R1", h, 1, "default high phase");
    check("R1", l, 1, "default low phase");

    // R3 vector walk over the fast codes
    for (int i = 0; i < 6; i++) begin
      writeReg(8'(VCODE[i]), 8'h07);
      check("R2", regRdata[2:0], VCODE[i], "field readback");
      measure(h, l, 400);
      measure(h, l, 400);
      check("R3", h, VHALF[i], "high phase");
      check("R3", l, VHALF[i], "low phase");
    end

    // R9 upper bits are storage only (code 5 active)
    writeReg(8'hF8, 8'hF8);
    check("R9", regRdata, 8'hFD, "readback after upper write");
    measure(h, l, 400);
    measure(h, l, 400);
    check("R9", h, 32, "high phase unchanged");
    check("R9", l, 32, "low phase unchanged");
    // R2 zero mask changes nothing
    writeReg(8'hAB, 8'h00);
    check("R2", regRdata, 8'hFD, "masked-off write");

    // R6 switch 5 -> 0 in the middle of a high pulse
    while (clkOut !== 1'b0) @(negedge clk);
    while (clkOut !== 1'b1) @(negedge clk);
    run = 1;
    regWe = 1'b1; regWdata = 8'h00; regWmask = 8'h07;
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      regWe = 1'b0;
      if (clkOut === 1'b1) run++;
      else break;
    end
    check("R6", run, 32, "in-flight high pulse length");
    measure(h, l, 100);
    check("R6", h, 1, "new rate high after fall");
    check("R6", l, 1, "new rate low after fall");

    // R7 switch 0 -> 4, every high run must be 1 or 16 cycles
    writeReg(8'h04, 8'h07);
    bad = 0; run = 0; seen16 = 0;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if (clkOut === 1'b1) run++;
      else begin
        if (run == 16) seen16++;
        else if (run != 0 && run != 1) bad++;
        run = 0;
      end
    end
    check("R7", bad, 0, "runt high pulses");
    check("R7", int'(seen16 > 0), 1, "full slow pulses seen");

    // R5 off holds low
    writeReg(8'h07, 8'h07);
    check("R5", regRdata[2:0], 7, "off code readback");
    repeat (40) @(negedge clk);
    highs = 0;
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      if (clkOut !== 1'b0) highs++;
    end
    check("R5", highs, 0, "high samples while off");

    // R8 from off straight to code 5: first pulse full
    writeReg(8'h05, 8'h07);
    measure(h, l, 400);
    check("R8", h, 32, "first high after leaving off");

    // R4 slow tap
    writeReg(8'h06, 8'h07);
    measure(h, l, 140000);
    check("R4", h, 32768, "slow high phase");
    check("R4", l, 32768, "slow low phase");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule